// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides, one frame at a time, whether an incoming Ethernet frame is kept. The MAC framing logic presents the frame's destination address, its length and its CRC and alignment error flags for one cycle. One clock edge later the filter returns an accept decision, a store decision for the buffer writer, and a receive-status word that describes the frame.

The address decision covers three cases. A unicast destination must equal the programmed station address, unless promiscuous mode is on. A broadcast destination is taken only when broadcast acceptance is enabled. Any other group (multicast) destination goes through a 64-bin hash table: the bin index comes from the CRC-32 of the destination, and that CRC logic is part of the block.

Two policy rules then apply on top of the address decision. Short frames and errored frames are dropped unless their acceptance bits are set. In monitor mode frames are still judged but none is stored. An auto-transmit-disable option lets two reserved hash bins switch a transmitter-enable output off and on.

Top module: `rx_addr_filter`

## Requirements
- R1: One cycle after a cycle with `frame_valid` high, `dec_valid` is 1. In every other cycle `dec_valid`, `accept`, `store` and `rx_status` are 0. Reset leaves `tx_enable` at 1 and all other outputs at 0.
- R2: A destination whose bit 0 is 0 (unicast) passes the address check if and only if it equals `station_addr` or promiscuous mode (`rx_cfg[0]`) is 1. Byte 0, the first byte on the wire, is `dest_addr[7:0]`.
- R3: The all-ones destination (broadcast) passes the address check if and only if `rx_cfg[1]` is 1.
- R4: Any other destination with bit 0 set (multicast) is rejected when `rx_cfg[2]` is 0. When `rx_cfg[2]` is 1 it passes if and only if `hash_table[k]` is 1. The bin index k is bits 31..26 of a CRC register that is preset to all ones and shifted MSB-first with polynomial 0x04C11DB7. The address is fed into it bit 0 of byte 0 first, and no final inversion is applied.
- R5: A frame with `frame_len` below 64 is rejected unless `rx_cfg[3]` is 1. A length of 64 is never a runt.
- R6: A frame with `crc_err` or `align_err` set is rejected unless `rx_cfg[4]` is 1. Status bit 1 is set for either error, and status bit 2 only for an alignment error.
- R7: While monitor mode (`rx_cfg[5]`) is 1, `store` is 0. Status bit 3 (missed) is 1 for every frame that passed the other checks, and status bit 5 (receiver off) is 1.
- R8: Status bit 4 is 0 for a unicast destination and 1 for a multicast or broadcast destination, whether or not the frame is accepted.
- R9: With `atd_en` at 1, a multicast (non-broadcast) frame hashing to bin 62 clears `tx_enable`, and one hashing to bin 63 sets it, one cycle later. With `atd_en` at 0, or for any other frame, `tx_enable` holds.
- R10: With monitor mode off, `store` equals `accept`.
- R11: Status bit 0 (good) is 1 exactly when the frame is accepted and carries neither error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | Frame attributes are valid this cycle |
| dest_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| frame_len | input | 16 | Frame length in bytes |
| crc_err | input | 1 | Frame has a CRC error |
| align_err | input | 1 | Frame has an alignment error |
| rx_cfg | input | 6 | Receive configuration: promiscuous, broadcast, multicast, runt, keep errored, monitor |
| station_addr | input | 48 | Station address, same byte order as dest_addr |
| hash_table | input | 64 | Multicast hash bins, bin 0 in bit 0 |
| atd_en | input | 1 | Enable hash-triggered transmitter disable and enable |
| dec_valid | output | 1 | Decision outputs are valid |
| accept | output | 1 | Frame accepted |
| store | output | 1 | Frame to be written to the buffer |
| rx_status | output | 6 | good, crc, align, missed, group, receiver off (bits 0..5) |
| tx_enable | output | 1 | Transmitter enable |

## Verification
The address path is tried with five kinds of destination: the exact station address, a unicast address one byte off from it, broadcast, and multicast addresses picked so that they land in a set bin or in a cleared bin. Together these separate a wrong station compare, a wrong broadcast test and a wrong hash order or bin lookup. Lengths of 63 and 64 pin the runt boundary, and single error flags show the two error status bits apart. Multicast addresses found to hash to bins 62 and 63, each sent with auto-transmit-disable on and off, check the transmitter toggle. Random configurations, tables and frames then cross all the rules against a bench model.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
   // receive configuration bit positions
   localparam int CFG_W        = 6;
   localparam int CFG_PROMISC  = 0;
   localparam int CFG_BCAST    = 1;
   localparam int CFG_MCAST    = 2;
   localparam int CFG_RUNT     = 3;
   localparam int CFG_KEEP_ERR = 4;
   localparam int CFG_MONITOR  = 5;

   // receive status bit positions
   localparam int STS_W      = 6;
   localparam int STS_GOOD   = 0;
   localparam int STS_CRC    = 1;
   localparam int STS_ALIGN  = 2;
   localparam int STS_MISSED = 3;
   localparam int STS_GROUP  = 4;
   localparam int STS_RXOFF  = 5;

   typedef struct packed {
      logic is_group;
      logic is_bcast;
      logic station_hit;
      logic hash_hit;
   } addr_class_t;
endpackage

// File: rtl/rxf_hash.sv
module rxf_hash #(
   parameter int          ADDR_W    = 48,
   parameter int          HASH_BITS = 6,
   parameter logic [31:0] POLY      = 32'h04C11DB7
) (
   input  logic [ADDR_W-1:0]    addr,
   output logic [HASH_BITS-1:0] bin
);
   localparam int CRC_W = 32;

   generate
      if (HASH_BITS < 1 || HASH_BITS > CRC_W) begin : g_bad_bits
         $error("rxf_hash: HASH_BITS must lie in 1..32");
      end
   endgenerate

   function automatic logic [CRC_W-1:0] crc_of(input logic [ADDR_W-1:0] a);
      logic [CRC_W-1:0] c;
      logic             fb;
      c = '1;
      for (int i = 0; i < ADDR_W; i++) begin
         fb = c[CRC_W-1] ^ a[i];
         c  = {c[CRC_W-2:0], 1'b0};
         if (fb) c = c ^ POLY;
      end
      return c;
   endfunction

   logic [CRC_W-1:0] crc;
   always_comb crc = crc_of(addr);
   assign bin = crc[CRC_W-1 -: HASH_BITS];
endmodule

// File: rtl/rxf_classify.sv
module rxf_classify
   import rxf_pkg::*;
#(
   parameter int ADDR_W    = 48,
   parameter int HASH_BITS = 6,
   localparam int BINS     = 1 << HASH_BITS,
   localparam int NBYTES   = ADDR_W / 8
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic [ADDR_W-1:0]    station,
   input  logic [BINS-1:0]      table_bits,
   input  logic [HASH_BITS-1:0] bin,
   output addr_class_t          cls
);
   generate
      if (ADDR_W % 8 != 0 || ADDR_W < 8) begin : g_bad_addr
         $error("rxf_classify: ADDR_W must be a whole number of bytes");
      end
   endgenerate

   logic [NBYTES-1:0] byte_eq;

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign byte_eq[b] = (addr[8*b +: 8] == station[8*b +: 8]);
      end
   endgenerate

   always_comb begin
      cls.is_group    = addr[0];
      cls.is_bcast    = &addr;
      cls.station_hit = &byte_eq;
      cls.hash_hit    = table_bits[bin];
   end
endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
   import rxf_pkg::*;
#(
   parameter int LEN_W   = 16,
   parameter int MIN_LEN = 64
) (
   input  addr_class_t      cls,
   input  logic [LEN_W-1:0] len,
   input  logic             crc_err,
   input  logic             align_err,
   input  logic [CFG_W-1:0] cfg,
   output logic             accept,
   output logic             store,
   output logic [STS_W-1:0] status
);
   generate
      if (MIN_LEN < 1 || MIN_LEN >= (1 << LEN_W)) begin : g_bad_len
         $error("rxf_decide: MIN_LEN does not fit LEN_W");
      end
   endgenerate

   logic addr_ok, any_err, runt, len_ok, err_ok;

   always_comb begin
      any_err = crc_err | align_err;
      runt    = len < LEN_W'(MIN_LEN);
      if (cls.is_bcast)      addr_ok = cfg[CFG_BCAST];
      else if (cls.is_group) addr_ok = cfg[CFG_MCAST] & cls.hash_hit;
      else                   addr_ok = cfg[CFG_PROMISC] | cls.station_hit;
      len_ok  = ~runt | cfg[CFG_RUNT];
      err_ok  = ~any_err | cfg[CFG_KEEP_ERR];
      accept  = addr_ok & len_ok & err_ok;
      store   = accept & ~cfg[CFG_MONITOR];

      status             = '0;
      status[STS_GOOD]   = accept & ~any_err;
      status[STS_CRC]    = any_err;
      status[STS_ALIGN]  = align_err;
      status[STS_MISSED] = accept & cfg[CFG_MONITOR];
      status[STS_GROUP]  = cls.is_group;
      status[STS_RXOFF]  = cfg[CFG_MONITOR];
   end
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
   import rxf_pkg::*;
#(
   parameter int          ADDR_W    = 48,
   parameter int          LEN_W     = 16,
   parameter int          MIN_LEN   = 64,
   parameter int          HASH_BITS = 6,
   parameter logic [31:0] POLY      = 32'h04C11DB7,
   localparam int         BINS      = 1 << HASH_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_valid,
   input  logic [ADDR_W-1:0] dest_addr,
   input  logic [LEN_W-1:0]  frame_len,
   input  logic              crc_err,
   input  logic              align_err,
   input  logic [CFG_W-1:0]  rx_cfg,
   input  logic [ADDR_W-1:0] station_addr,
   input  logic [BINS-1:0]   hash_table,
   input  logic              atd_en,
   output logic              dec_valid,
   output logic              accept,
   output logic              store,
   output logic [STS_W-1:0]  rx_status,
   output logic              tx_enable
);
   localparam logic [HASH_BITS-1:0] BIN_TX_OFF = HASH_BITS'(BINS - 2);
   localparam logic [HASH_BITS-1:0] BIN_TX_ON  = HASH_BITS'(BINS - 1);

   generate
      if (HASH_BITS < 2) begin : g_bad_hash
         $error("rx_addr_filter: HASH_BITS must be at least 2");
      end
   endgenerate

   logic [HASH_BITS-1:0] bin;
   addr_class_t          cls;
   logic                 acc_d, sto_d;
   logic [STS_W-1:0]     sts_d;

   rxf_hash #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS), .POLY(POLY)) u_hash (
      .addr (dest_addr),
      .bin  (bin)
   );

   rxf_classify #(.ADDR_W(ADDR_W), .HASH_BITS(HASH_BITS)) u_class (
      .addr       (dest_addr),
      .station    (station_addr),
      .table_bits (hash_table),
      .bin        (bin),
      .cls        (cls)
   );

   rxf_decide #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_decide (
      .cls       (cls),
      .len       (frame_len),
      .crc_err   (crc_err),
      .align_err (align_err),
      .cfg       (rx_cfg),
      .accept    (acc_d),
      .store     (sto_d),
      .status    (sts_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dec_valid <= 1'b0;
         accept    <= 1'b0;
         store     <= 1'b0;
         rx_status <= '0;
      end else begin
         dec_valid <= frame_valid;
         accept    <= frame_valid & acc_d;
         store     <= frame_valid & sto_d;
         rx_status <= frame_valid ? sts_d : '0;
      end
   end

   // hash-triggered transmitter control
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_enable <= 1'b1;
      end else if (frame_valid && atd_en && cls.is_group && !cls.is_bcast) begin
         if (bin == BIN_TX_OFF)     tx_enable <= 1'b0;
         else if (bin == BIN_TX_ON) tx_enable <= 1'b1;
      end
   end

   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> dec_valid);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |=> (!accept && !store && rx_status == '0));

   a_r2_foreign_unicast: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && !dest_addr[0] && !rx_cfg[CFG_PROMISC] && dest_addr != station_addr)
      |=> !accept);

   a_r5_runt_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && frame_len < LEN_W'(MIN_LEN) && !rx_cfg[CFG_RUNT]) |=> !accept);

   a_r6_err_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && (crc_err || align_err) && !rx_cfg[CFG_KEEP_ERR]) |=> !accept);

   a_r7_monitor_no_store: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_valid && rx_cfg[CFG_MONITOR]) |=> !store);

   a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_valid || !atd_en) |=> $stable(tx_enable));
endmodule

// File: tb/rx_addr_filter_test.sv
module rx_addr_filter_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        frame_valid = 1'b0;
   logic [47:0] dest_addr = '0;
   logic [15:0] frame_len = 16'd100;
   logic        crc_err = 1'b0, align_err = 1'b0;
   logic [5:0]  rx_cfg = '0;
   logic [47:0] station_addr = 48'h5544_3322_1100;
   logic [63:0] hash_table = '0;
   logic        atd_en = 1'b0;
   logic        dec_valid, accept, store, tx_enable;
   logic [5:0]  rx_status;

   int checks = 0, fails = 0;
   bit done = 0;
   logic exp_tx = 1'b1;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_addr_filter uut (
      .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .dest_addr(dest_addr),
      .frame_len(frame_len), .crc_err(crc_err), .align_err(align_err), .rx_cfg(rx_cfg),
      .station_addr(station_addr), .hash_table(hash_table), .atd_en(atd_en),
      .dec_valid(dec_valid), .accept(accept), .store(store), .rx_status(rx_status),
      .tx_enable(tx_enable)
   );

   function automatic logic [5:0] ref_bin(input logic [47:0] a);
      logic [31:0] c = 32'hFFFF_FFFF;
      for (int i = 0; i < 48; i++) begin
         logic top = c[31];
         c = c << 1;
         if (top ^ a[i]) c = c ^ 32'h04C11DB7;
      end
      return c[31:26];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [47:0] mc_for_bin(input logic [5:0] b);
      logic [47:0] a = 48'h0;
      for (int t = 0; t < 20000; t++) begin
         a = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
         a[0] = 1'b1;
         if (a != '1 && ref_bin(a) == b) return a;
      end
      return a;
   endfunction

   // apply one frame at a negedge, check the decision one edge later
   task automatic send(input logic [47:0] d, input logic [15:0] l, input logic ce, input logic ae);
      logic grp, bc, aok, acc, err, mon;
      logic [5:0] sts;
      logic [5:0] b;
      string tag;
      dest_addr = d; frame_len = l; crc_err = ce; align_err = ae; frame_valid = 1'b1;
      grp = d[0]; bc = (d == '1); b = ref_bin(d); err = ce | ae; mon = rx_cfg[5];
      if (bc)       begin aok = rx_cfg[1]; tag = "R3"; end
      else if (grp) begin aok = rx_cfg[2] & hash_table[b]; tag = "R4"; end
      else          begin aok = rx_cfg[0] | (d == station_addr); tag = "R2"; end
      acc = aok & ((l >= 16'd64) | rx_cfg[3]) & (~err | rx_cfg[4]);
      if (l < 16'd64) tag = {tag, " R5"};
      if (err) tag = {tag, " R6"};
      sts = {mon, grp, acc & mon, ae, err, acc & ~err};
      if (atd_en && grp && !bc) begin
         if (b == 6'd62) exp_tx = 1'b0;
         else if (b == 6'd63) exp_tx = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      frame_valid = 1'b0;
      check("R1 dec_valid", 64'(dec_valid), 64'd1);
      check({tag, " accept"}, 64'(accept), 64'(acc));
      check(mon ? "R7 store" : "R10 store", 64'(store), 64'(acc & ~mon));
      check("R6 R7 R8 R11 status", 64'(rx_status), 64'(sts));
      check("R9 tx_enable", 64'(tx_enable), 64'(exp_tx));
   endtask

   task automatic idle_check();
      @(posedge clk);
      @(negedge clk);
      check("R1 idle", 64'({dec_valid, accept, store, rx_status}), 64'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [47:0] mc62, mc63, mcx;
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R1 reset outputs", 64'({dec_valid, accept, store, rx_status}), 64'd0);
      check("R1 reset tx_enable", 64'(tx_enable), 64'd1);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: exact station, one byte off, promiscuous
      rx_cfg = 6'b000000;
      send(station_addr, 16'd100, 0, 0);
      send(station_addr ^ 48'h0000_0000_2000, 16'd100, 0, 0);
      rx_cfg = 6'b000001;
      send(station_addr ^ 48'h0000_0000_2000, 16'd100, 0, 0);
      idle_check();
      // R3: broadcast off/on
      rx_cfg = 6'b000000; send('1, 16'd80, 0, 0);
      rx_cfg = 6'b000010; send('1, 16'd80, 0, 0);
      // R4: multicast set bin vs cleared bin
      mcx = mc_for_bin(6'd17);
      hash_table = 64'h1 << 17;
      rx_cfg = 6'b000000; send(mcx, 16'd80, 0, 0);
      rx_cfg = 6'b000100; send(mcx, 16'd80, 0, 0);
      hash_table = ~(64'h1 << 17); send(mcx, 16'd80, 0, 0);
      // R5: runt boundary
      rx_cfg = 6'b000000;
      send(station_addr, 16'd63, 0, 0);
      send(station_addr, 16'd64, 0, 0);
      rx_cfg = 6'b001000; send(station_addr, 16'd63, 0, 0);
      // R6: errors
      rx_cfg = 6'b000000;
      send(station_addr, 16'd100, 1, 0);
      send(station_addr, 16'd100, 0, 1);
      rx_cfg = 6'b010000;
      send(station_addr, 16'd100, 0, 1);
      // R7: monitor
      rx_cfg = 6'b100000; send(station_addr, 16'd100, 0, 0);
      // R9: transmitter toggle
      mc62 = mc_for_bin(6'd62);
      mc63 = mc_for_bin(6'd63);
      rx_cfg = 6'b000100; hash_table = '1;
      atd_en = 1'b0; send(mc62, 16'd100, 0, 0);
      atd_en = 1'b1; send(mc62, 16'd100, 0, 0);
      send(mcx, 16'd100, 0, 0);
      idle_check();
      send(mc63, 16'd100, 0, 0);
      send(mc62, 16'd100, 0, 0);
      atd_en = 1'b0; send(mc63, 16'd100, 0, 0);
      atd_en = 1'b1; send(mc63, 16'd100, 0, 0);

      // random frames
      for (int n = 0; n < 400; n++) begin
         logic [47:0] d;
         int kind;
         rx_cfg = 6'($urandom());
         atd_en = 1'($urandom());
         hash_table = {$urandom(), $urandom()};
         kind = $urandom_range(0, 5);
         case (kind)
            0: d = station_addr;
            1: d = station_addr ^ (48'h1 << (8 * $urandom_range(0, 5) + 1));
            2: d = '1;
            3: d = mc_for_bin(6'($urandom_range(62, 63)));
            default: begin
               d = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
               if (kind == 4) d[0] = 1'b1;
            end
         endcase
         send(d, 16'($urandom_range(40, 100)), ($urandom_range(0, 3) == 0),
              ($urandom_range(0, 3) == 0));
         if ($urandom_range(0, 7) == 0) idle_check();
      end

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule